// File: doc/BRIEF.md
# DAC Code Gain and Offset Calibration Bank

The block holds the digital trim state for a bank of DAC levels: four channels with five levels each (force, clamp high, clamp low, compare high, compare low). Each level keeps a raw input code, a gain word and an offset word. Any write to one of these three words recomputes that level's calibrated code. The new code is the raw code scaled by (gain+1)/65536, truncated, shifted by the offset relative to midscale, and clamped to the 16-bit range. It is then stored and presented on a strobed output port.

With default trim words the raw code passes through unchanged. A system therefore only has to load gain and offset words for levels whose signal chain needs trimming. A single 16-bit range-offset word, shared by the whole bank, is also kept here for the analog side to use. Access goes through a flat write port and a combinational read port. Both ports select the channel, the level and the register type.

Top module: `dac_cal_bank`

## Requirements
- R1: After reset every level reads X1 = 0x0000, gain = 0xFFFF, offset = 0x8000 and calibrated code = 0x0000, and the shared range word reads 0xA492. The register-select codes are 0 = X1, 1 = gain, 2 = offset, 3 = calibrated code (read only) and 4 = shared range word.
- R2: The calibrated code equals floor((gain+1) × X1 / 65536) + offset − 32768. The product is truncated, never rounded.
- R3: A result below 0 is stored as 0x0000, and a result above 65535 is stored as 0xFFFF.
- R4: Bit 0 of the gain word is ignored on writes. It is stored and read back as 1, so a written 0x7FFE acts as, and reads as, 0x7FFF.
- R5: A write to X1, gain or offset of a valid level raises x2_vld_o in the next cycle, for one cycle. In that cycle x2_o, x2_ch_o and x2_lvl_o carry the new code, the channel and the level, and a readback of the calibrated code returns the same value.
- R6: A write of select codes 0 to 3 with channel ≥ 4 or level ≥ 5 changes no register and produces no strobe. It raises err_o in the next cycle, for one cycle.
- R7: A write to one level leaves every other level's registers unchanged.
- R8: A write of select code 3 changes nothing and produces no strobe or error. The shared range word can be written and read back with select code 4, whatever the channel and level inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_ch_i | input | 3 | Write channel index |
| wr_lvl_i | input | 3 | Write level index |
| wr_sel_i | input | 3 | Write register select |
| wr_data_i | input | 16 | Write data |
| rd_ch_i | input | 3 | Read channel index |
| rd_lvl_i | input | 3 | Read level index |
| rd_sel_i | input | 3 | Read register select |
| rd_data_o | output | 16 | Read data (combinational) |
| x2_vld_o | output | 1 | Calibrated code update strobe |
| x2_ch_o | output | 3 | Channel of the updated code |
| x2_lvl_o | output | 3 | Level of the updated code |
| x2_o | output | 16 | Updated calibrated code |
| err_o | output | 1 | Out-of-range write flag |

## Verification
The cases that are hardest to reach from the ports are the ones where only one low-order bit decides the outcome. These are the forced gain bit and the truncation of a product just below one unit. The stimulus uses gain words such as 0x7FFE and 0xFFFD with small raw codes, chosen so that a design that keeps bit 0 or rounds the product reads back a code that differs by one. Aliasing of out-of-range indices is checked with a level index of 5 on channel 0: it flattens onto channel 1, level 0, and that level is read back afterwards to confirm it is untouched.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;
  typedef enum logic [2:0] {
    SEL_X1  = 3'd0,
    SEL_M   = 3'd1,
    SEL_C   = 3'd2,
    SEL_X2  = 3'd3,
    SEL_OFS = 3'd4
  } sel_e;

  localparam logic [15:0] M_RST   = 16'hFFFF;
  localparam logic [15:0] C_RST   = 16'h8000;
  localparam logic [15:0] OFS_RST = 16'hA492;
endpackage

// File: rtl/dac_cal_math.sv
module dac_cal_math #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] x1_i,
  input  logic [DW-1:0] m_i,
  input  logic [DW-1:0] c_i,
  output logic [DW-1:0] x2_o
);
  logic [DW:0]            gain;
  logic [2*DW:0]          prod;
  logic [DW:0]            scaled;
  logic signed [DW+2:0]   sum;

  assign gain   = {1'b0, m_i} + {{DW{1'b0}}, 1'b1};
  assign prod   = (2*DW+1)'(gain) * (2*DW+1)'(x1_i);
  assign scaled = prod[2*DW:DW];  // truncating shift
  assign sum    = signed'({2'b00, scaled}) + signed'({3'b000, c_i})
                - signed'((DW+3)'(1 << (DW-1)));

  always_comb begin
    if (sum[DW+2])                 x2_o = '0;
    else if (sum[DW+1:DW] != 2'b0) x2_o = '1;
    else                           x2_o = sum[DW-1:0];
  end

  // R2
  always_comb begin
    if (m_i == '1 && c_i == DW'(1 << (DW-1)))
      unity_pass_chk: assert (x2_o == x1_i);
  end
endmodule

// File: rtl/dac_cal_level.sv
module dac_cal_level
  import dac_cal_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_x1_i,
  input  logic          wr_m_i,
  input  logic          wr_c_i,
  input  logic          upd_i,
  input  logic [DW-1:0] d_i,
  input  logic [DW-1:0] x2_i,
  output logic [DW-1:0] x1_o,
  output logic [DW-1:0] m_o,
  output logic [DW-1:0] c_o,
  output logic [DW-1:0] x2_o
);
  logic [DW-1:0] x1_q, m_q, c_q, x2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x1_q <= '0;
      m_q  <= DW'(M_RST);
      c_q  <= DW'(C_RST);
      x2_q <= '0;
    end else begin
      if (wr_x1_i) x1_q <= d_i;
      if (wr_m_i)  m_q  <= {d_i[DW-1:1], 1'b1};
      if (wr_c_i)  c_q  <= d_i;
      if (upd_i)   x2_q <= x2_i;
    end
  end

  assign x1_o = x1_q;
  assign m_o  = m_q;
  assign c_o  = c_q;
  assign x2_o = x2_q;

  // R7
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_x1_i || wr_m_i || wr_c_i) |=> $stable(x1_q) && $stable(m_q) && $stable(c_q));

  // R7
  x2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(x2_q));
endmodule

// File: rtl/dac_cal_bank.sv
module dac_cal_bank
  import dac_cal_pkg::*;
#(
  parameter int CH_N  = 4,
  parameter int LVL_N = 5,
  parameter int DW    = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_ch_i,
  input  logic [IDX_W-1:0] wr_lvl_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_ch_i,
  input  logic [IDX_W-1:0] rd_lvl_i,
  input  logic [2:0]       rd_sel_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             x2_vld_o,
  output logic [IDX_W-1:0] x2_ch_o,
  output logic [IDX_W-1:0] x2_lvl_o,
  output logic [DW-1:0]    x2_o,
  output logic             err_o
);
  localparam int LEV_N = CH_N * LVL_N;
  localparam int LEV_W = $clog2(LEV_N);
  localparam int FL_W  = 2 * IDX_W;
  localparam logic [IDX_W-1:0] CH_LIM  = IDX_W'(CH_N);
  localparam logic [IDX_W-1:0] LVL_LIM = IDX_W'(LVL_N);

  logic [DW-1:0] x1_a [LEV_N];
  logic [DW-1:0] m_a  [LEV_N];
  logic [DW-1:0] c_a  [LEV_N];
  logic [DW-1:0] x2_a [LEV_N];

  logic            wr_ok, wr_lvl_sel, upd;
  logic [FL_W-1:0] wr_flat, rd_flat;
  logic [LEV_W-1:0] wr_idx, rd_idx;
  logic            rd_ok;
  logic [DW-1:0]   x1_n, m_n, c_n, x2_n;

  assign wr_ok      = (wr_ch_i < CH_LIM) && (wr_lvl_i < LVL_LIM);
  assign wr_lvl_sel = (wr_sel_i == SEL_X1) || (wr_sel_i == SEL_M)
                   || (wr_sel_i == SEL_C)  || (wr_sel_i == SEL_X2);
  assign upd        = wr_en_i && wr_ok && wr_lvl_sel && (wr_sel_i != SEL_X2);
  assign wr_flat    = FL_W'(wr_ch_i) * FL_W'(LVL_N) + FL_W'(wr_lvl_i);
  assign wr_idx     = wr_flat[LEV_W-1:0];

  // new value substituted so X2 tracks the write in the same edge
  assign x1_n = (wr_sel_i == SEL_X1) ? wr_data_i : x1_a[wr_idx];
  assign m_n  = (wr_sel_i == SEL_M)  ? {wr_data_i[DW-1:1], 1'b1} : m_a[wr_idx];
  assign c_n  = (wr_sel_i == SEL_C)  ? wr_data_i : c_a[wr_idx];

  dac_cal_math #(.DW(DW)) u_math (
    .x1_i(x1_n), .m_i(m_n), .c_i(c_n), .x2_o(x2_n)
  );

  for (genvar i = 0; i < LEV_N; i++) begin : g_lvl
    logic hit;
    assign hit = upd && (wr_idx == LEV_W'(i));
    dac_cal_level #(.DW(DW)) u_lvl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_x1_i (hit && (wr_sel_i == SEL_X1)),
      .wr_m_i  (hit && (wr_sel_i == SEL_M)),
      .wr_c_i  (hit && (wr_sel_i == SEL_C)),
      .upd_i   (hit),
      .d_i     (wr_data_i),
      .x2_i    (x2_n),
      .x1_o    (x1_a[i]),
      .m_o     (m_a[i]),
      .c_o     (c_a[i]),
      .x2_o    (x2_a[i])
    );
  end

  logic [DW-1:0] ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q    <= DW'(OFS_RST);
      x2_vld_o <= 1'b0;
      x2_ch_o  <= '0;
      x2_lvl_o <= '0;
      x2_o     <= '0;
      err_o    <= 1'b0;
    end else begin
      x2_vld_o <= upd;
      err_o    <= wr_en_i && wr_lvl_sel && !wr_ok;
      if (wr_en_i && wr_sel_i == SEL_OFS) ofs_q <= wr_data_i;
      if (upd) begin
        x2_ch_o  <= wr_ch_i;
        x2_lvl_o <= wr_lvl_i;
        x2_o     <= x2_n;
      end
    end
  end

  assign rd_ok   = (rd_ch_i < CH_LIM) && (rd_lvl_i < LVL_LIM);
  assign rd_flat = FL_W'(rd_ch_i) * FL_W'(LVL_N) + FL_W'(rd_lvl_i);
  assign rd_idx  = rd_flat[LEV_W-1:0];

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i == SEL_OFS) rd_data_o = ofs_q;
    else if (rd_ok) begin
      case (rd_sel_i)
        SEL_X1:  rd_data_o = x1_a[rd_idx];
        SEL_M:   rd_data_o = m_a[rd_idx];
        SEL_C:   rd_data_o = c_a[rd_idx];
        SEL_X2:  rd_data_o = x2_a[rd_idx];
        default: rd_data_o = '0;
      endcase
    end
  end

  // R5
  vld_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(x2_vld_o) |-> $past(wr_en_i));

  // R5
  vld_idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x2_vld_o |-> (x2_ch_o < CH_LIM) && (x2_lvl_o < LVL_LIM));

  // R6
  bad_idx_no_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !x2_vld_o);

  // R6
  err_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(wr_en_i));
endmodule

// File: tb/dac_cal_bank_tb.sv
module dac_cal_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_ch = '0, wr_lvl = '0, wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_ch = '0, rd_lvl = '0, rd_sel = '0;
  logic [15:0] rd_data;
  logic        x2_vld, err;
  logic [2:0]  x2_ch, x2_lvl;
  logic [15:0] x2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dac_cal_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_lvl_i(wr_lvl), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data),
    .rd_ch_i(rd_ch), .rd_lvl_i(rd_lvl), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .x2_vld_o(x2_vld), .x2_ch_o(x2_ch), .x2_lvl_o(x2_lvl), .x2_o(x2),
    .err_o(err)
  );

  // ch, lvl, x1, m, c, expected X2
  localparam logic [15:0] VEC [8][6] = '{
    '{16'd0, 16'd0, 16'h1234, 16'hFFFF, 16'h8000, 16'h1234},
    '{16'd1, 16'd2, 16'h8000, 16'h7FFF, 16'h8000, 16'h4000},
    '{16'd3, 16'd4, 16'hFFFF, 16'hFFFF, 16'h8100, 16'hFFFF},
    '{16'd2, 16'd1, 16'h0010, 16'hFFFF, 16'h7F00, 16'h0000},
    '{16'd0, 16'd4, 16'h0003, 16'h0000, 16'h8005, 16'h0005},
    '{16'd3, 16'd0, 16'h1000, 16'h7FFE, 16'h8000, 16'h0800},
    '{16'd1, 16'd1, 16'h0001, 16'hFFFD, 16'h8000, 16'h0000},
    '{16'd2, 16'd3, 16'hFFFF, 16'hFFFF, 16'h8000, 16'hFFFF}
  };

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ch, input logic [2:0] lvl,
                    input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch; wr_lvl = lvl; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ch, input logic [2:0] lvl,
                    input logic [2:0] sel, output logic [15:0] d);
    rd_ch = ch; rd_lvl = lvl; rd_sel = sel;
    #1;
    d = rd_data;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, 3'd3, 3'd0, v); chk(v == 16'h0000, "R1 X1 reset", v, 16'h0000);
    rd(3'd2, 3'd3, 3'd1, v); chk(v == 16'hFFFF, "R1 gain reset", v, 16'hFFFF);
    rd(3'd2, 3'd3, 3'd2, v); chk(v == 16'h8000, "R1 offset reset", v, 16'h8000);
    rd(3'd2, 3'd3, 3'd3, v); chk(v == 16'h0000, "R1 X2 reset", v, 16'h0000);
    rd(3'd0, 3'd0, 3'd4, v); chk(v == 16'hA492, "R1 range word reset", v, 16'hA492);
    chk(!x2_vld && !err, "R1 strobes idle", {14'd0, x2_vld, err}, 16'h0000);

    // R2/R3 vector walk; R5 strobe timing
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][0][2:0], VEC[i][1][2:0], 3'd2, VEC[i][4]);
      wr(VEC[i][0][2:0], VEC[i][1][2:0], 3'd1, VEC[i][3]);
      wr(VEC[i][0][2:0], VEC[i][1][2:0], 3'd0, VEC[i][2]);
      chk(x2_vld && x2 == VEC[i][5], $sformatf("R2/R3 vec %0d x2_o", i), x2, VEC[i][5]);
      chk(x2_ch == VEC[i][0][2:0] && x2_lvl == VEC[i][1][2:0],
          $sformatf("R5 vec %0d index", i), {10'd0, x2_ch, x2_lvl},
          {10'd0, VEC[i][0][2:0], VEC[i][1][2:0]});
      rd(VEC[i][0][2:0], VEC[i][1][2:0], 3'd3, v);
      chk(v == VEC[i][5], $sformatf("R5 vec %0d readback", i), v, VEC[i][5]);
      @(negedge clk);
      chk(!x2_vld, $sformatf("R5 vec %0d strobe one cycle", i), {15'd0, x2_vld}, 16'h0000);
    end

    // R4 gain bit 0 forced
    rd(3'd3, 3'd0, 3'd1, v); chk(v == 16'h7FFF, "R4 gain readback", v, 16'h7FFF);
    rd(3'd1, 3'd2, 3'd1, v); chk(v == 16'h7FFF, "R4 gain odd readback", v, 16'h7FFF);

    // R7 earlier levels untouched
    rd(3'd0, 3'd0, 3'd3, v); chk(v == 16'h1234, "R7 level 0/0 X2", v, 16'h1234);
    rd(3'd0, 3'd0, 3'd0, v); chk(v == 16'h1234, "R7 level 0/0 X1", v, 16'h1234);
    rd(3'd3, 3'd3, 3'd0, v); chk(v == 16'h0000, "R7 unwritten level X1", v, 16'h0000);

    // R6 bad channel
    wr(3'd4, 3'd0, 3'd0, 16'hBEEF);
    chk(err && !x2_vld, "R6 bad channel err", {14'd0, err, x2_vld}, 16'h0002);
    rd(3'd0, 3'd0, 3'd0, v); chk(v == 16'h1234, "R6 bad channel no write", v, 16'h1234);
    @(negedge clk);
    chk(!err, "R6 err one cycle", {15'd0, err}, 16'h0000);

    // R6 bad level on ch0 flattens onto ch1/lvl0
    wr(3'd0, 3'd5, 3'd0, 16'hBEEF);
    chk(err && !x2_vld, "R6 bad level err", {14'd0, err, x2_vld}, 16'h0002);
    rd(3'd1, 3'd0, 3'd0, v); chk(v == 16'h0000, "R6 no alias write", v, 16'h0000);
    rd(3'd0, 3'd4, 3'd2, v); chk(v == 16'h8005, "R6 level 4 intact", v, 16'h8005);

    // R8 X2 write ignored
    wr(3'd1, 3'd2, 3'd3, 16'hAAAA);
    chk(!err && !x2_vld, "R8 X2 write no strobe", {14'd0, err, x2_vld}, 16'h0000);
    rd(3'd1, 3'd2, 3'd3, v); chk(v == 16'h4000, "R8 X2 write ignored", v, 16'h4000);

    // R8 shared range word
    wr(3'd6, 3'd7, 3'd4, 16'h1111);
    chk(!x2_vld && !err, "R8 range write no strobe", {14'd0, err, x2_vld}, 16'h0000);
    rd(3'd2, 3'd2, 3'd4, v); chk(v == 16'h1111, "R8 range readback", v, 16'h1111);

    // R2 offset-only update with gain kept
    wr(3'd0, 3'd0, 3'd2, 16'h8010);
    chk(x2_vld && x2 == 16'h1244, "R2 offset update", x2, 16'h1244);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0x0000 expected 0x0001");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule